// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks atomic-sequence reservations for a set of requesters that share one cache. Each requester owns one reservation slot holding a valid bit and a line address. When a memory access completes, the block updates the slots and, one cycle later, reports a success flag. The flag is 0 only for a store-conditional that no longer holds its reservation. A separate invalidate strobe removes reservations on a line whose coherence permission has been lost. The cache data is stored elsewhere.

The block also tracks a line held by a locked read-modify-write sequence. The read half of the sequence marks the line as held, and the matching write half releases it. Other logic uses the held line to stall further requests to it. Reservations are checked in parallel: one comparator per slot, with no search loop. The operation codes are 3 bits: 0 plain read, 1 load-linked, 2 store-conditional, 3 plain write, 4 locked-RMW read, 5 locked-RMW write, 6 and 7 reserved.

Top module: `rsv_monitor`

## Requirements
- R1: A load-linked (code 1) completing on a present line sets the requester's slot to valid with that line, and its success flag is 1.
- R2: A store-conditional (code 2) on a present line returns 1 only when the requester's slot is valid and holds the same line; otherwise it returns 0. It is judged on the slot state from before that cycle.
- R3: Every store-conditional on a present line clears every slot holding that line, whether it succeeds or fails.
- R4: A plain write (3), locked-RMW read (4) or locked-RMW write (5) clears the requester's own slot if that slot holds the same line. Other requesters' slots are left unchanged, and the success flag is 1.
- R5: An invalidate clears every slot holding the invalidated line. When it arrives in the same cycle as a completion, it is applied after that completion's update.
- R6: When the completion marks the line as absent from the cache, the success flag is 1 and no slot changes.
- R7: A locked-RMW read sets blk_valid with its line. A locked-RMW write to the held line clears it, and one to any other line has no effect. After reset, no line is held.
- R8: res_valid is high exactly in the cycle after each completion strobe and low otherwise. It is 0 after reset.
- R9: A load-linked replaces any earlier reservation of the same requester and clears other requesters' slots on that line. A plain read (0) and the codes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | A completion is presented this cycle |
| cmp_op | input | 3 | Operation code of the completion |
| cmp_line | input | LINE_AW | Line address of the completion |
| cmp_req | input | log2(NUM_REQ) | Requester identity |
| cmp_present | input | 1 | The line is present in the tracked cache |
| inv_valid | input | 1 | Coherence permission lost on a line |
| inv_line | input | LINE_AW | Line whose permission was lost |
| res_valid | output | 1 | Success flag valid |
| res_ok | output | 1 | Success flag |
| blk_valid | output | 1 | A line is held by a locked RMW sequence |
| blk_line | output | LINE_AW | The held line |

## Verification
The bench targets these corner cases, and each one exposes a specific design error:
- A store-conditional to a line reserved by a different requester. A design that ignored the owner would wrongly report success.
- A failing store-conditional that must still clear another requester's reservation. A design that cleared only on success would let the later store-conditional succeed.
- A write by a foreign requester. A design that cleared every match would fail that requester's next store-conditional.
- An invalidate in the same cycle as a load-linked or a store-conditional. A design that ordered them the wrong way would keep a dead reservation or fail a store that was still valid.
- Completions marked as absent, and locked writes to a line that is not held. Either would corrupt state silently if the design acted on them.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
   typedef enum logic [2:0] {
      OP_READ  = 3'd0,
      OP_LINK  = 3'd1,
      OP_COND  = 3'd2,
      OP_WRITE = 3'd3,
      OP_LK_RD = 3'd4,
      OP_LK_WR = 3'd5,
      OP_RSV6  = 3'd6,
      OP_RSV7  = 3'd7
   } op_e;

   function automatic logic clears_own(op_e op);
      return (op == OP_WRITE) || (op == OP_LK_RD) || (op == OP_LK_WR);
   endfunction
endpackage

// File: rtl/rsv_slot.sv
module rsv_slot
   import rsv_pkg::*;
#(
   parameter int LINE_AW = 8,
   parameter int IDW     = 2,
   parameter int SLOT_ID = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  op_e                op,
   input  logic [LINE_AW-1:0] cmp_line,
   input  logic [IDW-1:0]     cmp_req,
   input  logic               inv_valid,
   input  logic [LINE_AW-1:0] inv_line,
   output logic               hold_valid,
   output logic [LINE_AW-1:0] hold_line,
   output logic               line_match
);
   logic               own;
   logic               nxt_v;
   logic [LINE_AW-1:0] nxt_l;

   assign own        = (cmp_req == IDW'(SLOT_ID));
   assign line_match = hold_valid && (hold_line == cmp_line);

   always_comb begin
      nxt_v = hold_valid;
      nxt_l = hold_line;
      if (fire) begin
         case (op)
            OP_LINK: begin
               if (own) begin
                  nxt_v = 1'b1;
                  nxt_l = cmp_line;
               end else if (line_match) begin
                  nxt_v = 1'b0;
               end
            end
            OP_COND: if (line_match) nxt_v = 1'b0;
            OP_WRITE, OP_LK_RD, OP_LK_WR: if (own && line_match) nxt_v = 1'b0;
            default: ;
         endcase
      end
      // invalidate is ordered after the completion update
      if (inv_valid && nxt_v && (nxt_l == inv_line)) nxt_v = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_line  <= '0;
      end else begin
         hold_valid <= nxt_v;
         hold_line  <= nxt_l;
      end
   end

   p_link_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fire && op == OP_LINK && own && !(inv_valid && inv_line == cmp_line)
      |=> hold_valid && hold_line == $past(cmp_line));

   p_cond_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire && op == OP_COND && line_match |=> !hold_valid);

   p_foreign_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fire && clears_own(op) && !own && !inv_valid
      |=> $stable(hold_valid) && $stable(hold_line));

   p_inv_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid && hold_valid && hold_line == inv_line && !(fire && op == OP_LINK && own)
      |=> !hold_valid);

   p_link_steals_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fire && op == OP_LINK && !own && line_match |=> !hold_valid);
endmodule

// File: rtl/rsv_block_track.sv
module rsv_block_track
   import rsv_pkg::*;
#(
   parameter int LINE_AW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmp_valid,
   input  op_e                op,
   input  logic [LINE_AW-1:0] cmp_line,
   output logic               blk_valid,
   output logic [LINE_AW-1:0] blk_line
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_valid <= 1'b0;
         blk_line  <= '0;
      end else if (cmp_valid) begin
         if (op == OP_LK_RD) begin
            blk_valid <= 1'b1;
            blk_line  <= cmp_line;
         end else if (op == OP_LK_WR && blk_valid && blk_line == cmp_line) begin
            blk_valid <= 1'b0;
         end
      end
   end

   p_lock_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid && op == OP_LK_RD |=> blk_valid && blk_line == $past(cmp_line));

   p_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid && op == OP_LK_WR && blk_valid && blk_line == cmp_line |=> !blk_valid);

   p_other_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid && op == OP_LK_WR && blk_line != cmp_line
      |=> $stable(blk_valid) && $stable(blk_line));
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
   import rsv_pkg::*;
#(
   parameter int NUM_REQ  = 4,
   parameter int LINE_AW  = 8,
   parameter bit BLOCK_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmp_valid,
   input  logic [2:0]                 cmp_op,
   input  logic [LINE_AW-1:0]         cmp_line,
   input  logic [$clog2(NUM_REQ)-1:0] cmp_req,
   input  logic                       cmp_present,
   input  logic                       inv_valid,
   input  logic [LINE_AW-1:0]         inv_line,
   output logic                       res_valid,
   output logic                       res_ok,
   output logic                       blk_valid,
   output logic [LINE_AW-1:0]         blk_line
);
   localparam int IDW = $clog2(NUM_REQ);

   if (NUM_REQ < 2 || (1 << IDW) != NUM_REQ) begin : g_bad_req
      $error("rsv_monitor: NUM_REQ must be a power of two, at least 2");
   end
   if (LINE_AW < 1) begin : g_bad_aw
      $error("rsv_monitor: LINE_AW must be positive");
   end

   op_e                              op;
   logic                             fire;
   logic [NUM_REQ-1:0]               slot_v;
   logic [NUM_REQ-1:0][LINE_AW-1:0]  slot_l;
   logic [NUM_REQ-1:0]               slot_m;
   logic                             own_hit;

   assign op      = op_e'(cmp_op);
   assign fire    = cmp_valid && cmp_present;
   assign own_hit = slot_m[cmp_req];

   for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
      rsv_slot #(.LINE_AW(LINE_AW), .IDW(IDW), .SLOT_ID(g)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .fire      (fire),
         .op        (op),
         .cmp_line  (cmp_line),
         .cmp_req   (cmp_req),
         .inv_valid (inv_valid),
         .inv_line  (inv_line),
         .hold_valid(slot_v[g]),
         .hold_line (slot_l[g]),
         .line_match(slot_m[g])
      );
   end

   if (BLOCK_EN) begin : g_blk
      rsv_block_track #(.LINE_AW(LINE_AW)) u_blk (
         .clk      (clk),
         .rst_n    (rst_n),
         .cmp_valid(cmp_valid),
         .op       (op),
         .cmp_line (cmp_line),
         .blk_valid(blk_valid),
         .blk_line (blk_line)
      );
   end else begin : g_noblk
      assign blk_valid = 1'b0;
      assign blk_line  = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_ok    <= 1'b0;
      end else begin
         res_valid <= cmp_valid;
         res_ok    <= !cmp_present || (op != OP_COND) || own_hit;
      end
   end

   p_res_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid |=> res_valid);

   p_res_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_valid |=> !res_valid);

   p_nonsc_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid && op != OP_COND |=> res_ok);

   p_sc_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid && cmp_present && op == OP_COND
      && !(slot_v[cmp_req] && slot_l[cmp_req] == cmp_line) |=> !res_ok);

   p_absent_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid && !cmp_present && !inv_valid |=> $stable(slot_v) && $stable(slot_l));
endmodule

// File: tb/sim_rsv_monitor.sv
`timescale 1ns/1ps
module sim_rsv_monitor;
   localparam int NQ  = 4;
   localparam int LAW = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cmp_valid = 1'b0;
   logic [2:0]     cmp_op = '0;
   logic [LAW-1:0] cmp_line = '0;
   logic [1:0]     cmp_req = '0;
   logic           cmp_present = 1'b0;
   logic           inv_valid = 1'b0;
   logic [LAW-1:0] inv_line = '0;
   logic           res_valid, res_ok, blk_valid;
   logic [LAW-1:0] blk_line;

   always #2.5 clk = ~clk;

   rsv_monitor #(.NUM_REQ(NQ), .LINE_AW(LAW), .BLOCK_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
      .cmp_line(cmp_line), .cmp_req(cmp_req), .cmp_present(cmp_present),
      .inv_valid(inv_valid), .inv_line(inv_line), .res_valid(res_valid),
      .res_ok(res_ok), .blk_valid(blk_valid), .blk_line(blk_line));

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;
   bit    m_v[NQ];
   int    m_l[NQ];
   bit    m_b  = 1'b0;
   int    m_bl = 0;
   bit    armed = 1'b0;
   bit    e_rv = 1'b0;
   bit    e_ok = 1'b0;
   string e_tag = "R8";

   task automatic check(bit cond, string tag, string what, int act, int exp);
      checks++;
      if (!cond) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic sample();
      if (armed) begin
         check(res_valid == e_rv, "R8", "res_valid", res_valid, e_rv);
         if (e_rv) check(res_ok == e_ok, e_tag, "res_ok", res_ok, e_ok);
         check(blk_valid == m_b, "R7", "blk_valid", blk_valid, m_b);
         if (m_b) check(blk_line == LAW'(m_bl), "R7", "blk_line", blk_line, m_bl);
      end
   endtask

   // model of the requirements
   task automatic model(int k, int r, int ln, bit pres, bit iv, int il);
      if (pres) begin
         case (k)
            1: begin
               for (int q = 0; q < NQ; q++)
                  if (q != r && m_v[q] && m_l[q] == ln) m_v[q] = 1'b0;
               m_v[r] = 1'b1;
               m_l[r] = ln;
            end
            2: for (int q = 0; q < NQ; q++)
                  if (m_v[q] && m_l[q] == ln) m_v[q] = 1'b0;
            3, 4, 5: if (m_v[r] && m_l[r] == ln) m_v[r] = 1'b0;
            default: ;
         endcase
      end
      if (k == 4) begin
         m_b  = 1'b1;
         m_bl = ln;
      end else if (k == 5 && m_b && m_bl == ln) begin
         m_b = 1'b0;
      end
      if (iv)
         for (int q = 0; q < NQ; q++)
            if (m_v[q] && m_l[q] == il) m_v[q] = 1'b0;
   endtask

   function automatic string tag_of(int k, bit pres);
      if (!pres)  return "R6";
      if (k == 2) return "R2";
      if (k == 1) return "R1";
      if (k == 0 || k > 5) return "R9";
      return "R4";
   endfunction

   task automatic op(int k, int r, int ln, bit pres, bit iv, int il, string tag);
      @(negedge clk);
      sample();
      cmp_valid   = 1'b1;
      cmp_op      = 3'(k);
      cmp_req     = 2'(r);
      cmp_line    = LAW'(ln);
      cmp_present = pres;
      inv_valid   = iv;
      inv_line    = LAW'(il);
      e_ok  = !pres || k != 2 || (m_v[r] && m_l[r] == ln);
      e_rv  = 1'b1;
      e_tag = (tag == "") ? tag_of(k, pres) : tag;
      model(k, r, ln, pres, iv, il);
      armed = 1'b1;
   endtask

   task automatic idle(bit iv, int il);
      @(negedge clk);
      sample();
      cmp_valid = 1'b0;
      inv_valid = iv;
      inv_line  = LAW'(il);
      e_rv = 1'b0;
      model(0, 0, 0, 1'b0, iv, il);
      armed = 1'b1;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      for (int q = 0; q < NQ; q++) begin m_v[q] = 1'b0; m_l[q] = 0; end
      repeat (3) @(negedge clk);
      // R8 / R7 reset state
      check(res_valid == 1'b0, "R8", "reset res_valid", res_valid, 0);
      check(blk_valid == 1'b0, "R7", "reset blk_valid", blk_valid, 0);
      rst_n = 1'b1;
      idle(0, 0);

      // R1: load-linked then matching store-conditional
      op(1, 0, 3, 1, 0, 0, "R1");
      op(2, 0, 3, 1, 0, 0, "R1");
      // R3: failing SC by another requester still clears the line
      op(1, 1, 5, 1, 0, 0, "R3");
      op(2, 2, 5, 1, 0, 0, "R3");
      op(2, 1, 5, 1, 0, 0, "R3");
      // R9: reservation replaced; foreign LL steals; reads have no effect
      op(1, 0, 2, 1, 0, 0, "R9");
      op(1, 0, 6, 1, 0, 0, "R9");
      op(2, 0, 2, 1, 0, 0, "R9");
      op(2, 0, 6, 1, 0, 0, "R9");
      op(1, 1, 7, 1, 0, 0, "R9");
      op(1, 3, 7, 1, 0, 0, "R9");
      op(2, 1, 7, 1, 0, 0, "R9");
      op(1, 2, 9, 1, 0, 0, "R9");
      op(0, 2, 9, 1, 0, 0, "R9");
      op(6, 2, 9, 1, 0, 0, "R9");
      op(7, 2, 9, 1, 0, 0, "R9");
      op(2, 2, 9, 1, 0, 0, "R9");
      // R4: foreign write keeps, own write clears
      op(1, 0, 4, 1, 0, 0, "R4");
      op(3, 1, 4, 1, 0, 0, "R4");
      op(2, 0, 4, 1, 0, 0, "R4");
      op(1, 0, 4, 1, 0, 0, "R4");
      op(3, 0, 4, 1, 0, 0, "R4");
      op(2, 0, 4, 1, 0, 0, "R4");
      // R5: invalidate alone, with LL, with SC in the same cycle
      op(1, 3, 4, 1, 0, 0, "R5");
      idle(1, 4);
      op(2, 3, 4, 1, 0, 0, "R5");
      op(1, 1, 8, 1, 1, 8, "R5");
      op(2, 1, 8, 1, 0, 0, "R5");
      op(1, 2, 10, 1, 0, 0, "R5");
      op(2, 2, 10, 1, 1, 10, "R5");
      // R6: absent lines change nothing and report success
      op(1, 0, 11, 1, 0, 0, "R6");
      op(2, 0, 11, 0, 0, 0, "R6");
      op(2, 0, 11, 1, 0, 0, "R6");
      op(1, 1, 12, 0, 0, 0, "R6");
      op(2, 1, 12, 1, 0, 0, "R6");
      // R7: lock hold and release
      op(4, 0, 3, 1, 0, 0, "R7");
      idle(0, 0);
      op(5, 0, 5, 1, 0, 0, "R7");
      op(5, 0, 3, 0, 0, 0, "R7");
      op(5, 1, 3, 1, 0, 0, "R7");
      // R8: idle gap
      idle(0, 0);
      idle(0, 0);

      // sweep: reservation of a, one op by b, then SC by a
      for (int a = 0; a < NQ; a++)
         for (int b = 0; b < NQ; b++)
            for (int k = 0; k < 8; k++)
               for (int s = 0; s < 2; s++) begin
                  op(1, a, 1, 1, 0, 0, "");
                  op(k, b, (s != 0) ? 1 : 2, 1, 0, 0, "");
                  op(2, a, 1, 1, 0, 0, "R2");
               end

      // pseudo-random mix on few lines
      for (int n = 0; n < 3000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[15:14] == 2'b00 && lfsr[3])
            idle(lfsr[4], int'(lfsr[6:5]));
         else
            op(int'(lfsr[2:0]) % 6, int'(lfsr[8:7]), int'(lfsr[10:9]),
               lfsr[13:11] != 3'b000, lfsr[6:4] == 3'b111, int'(lfsr[1:0]), "");
      end
      idle(0, 0);
      idle(0, 0);
      done = 1'b1;
      finish_run();
   end
endmodule